// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching an in-memory hashed page table. When a request is accepted, it latches the address, the access type and the privilege mode. It also latches the table base/size register and the segment register that the top four address bits select from a sixteen-entry segment file. From these it forms a hash and masks it into a group index, then reads the eight two-word entries of that group one word at a time over a word-read memory port. It compares the first word of each entry against a tag built from the segment identifier and the upper page bits.

If no entry in the first group matches, the walker complements the hash and searches a second group with a tag that carries a secondary marker bit. On a match it decodes a 3-bit protection key into read and write permission; execute is always granted. It then maintains the referenced and changed flags of the matching entry with single-byte writes, and only after that reports success or a protection fault. When neither group matches, it reports a miss. The result is held on the outputs, and a one-cycle done pulse marks when it is ready.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is `{base[31:16],16'h0} | (hash & mask)`, where `hash = ({4'b0,vsid} ^ {16'b0,ea[27:12]}) << 6`, `vsid` is bits 27..0 of segment register `ea[31:28]` (segment n at `segFile[32n+31:32n]`), and `mask = {7'b0, base[8:0], 16'hFFC0}`.
- R2: The secondary search runs only after all eight primary entries fail to match. It uses the bitwise complement of the hash before masking, and its tag has bit 6 (0x40) set, while the primary tag has it clear.
- R3: Entry i of a group occupies the word at group+8i and the word at group+8i+4. The match tag is `0x80000000 | (vsid<<7) | sec<<6 | ea[27:22]`, and the lowest-numbered entry whose first word equals the tag wins.
- R4: On a match, physAddr is the second word with bits 11..0 replaced by ea[11..0].
- R5: The key is `{k, w1[1:0]}`, where k is segment bit 29 in user mode or segment bit 30 in supervisor mode. Keys 0, 1, 2 and 6 give read and write, keys 3, 5 and 7 give read only, and key 4 gives neither. permExec is 1 on every match.
- R6: If the match is readable and second-word bit 8 is clear, the walker writes the byte `w1[15:8]|0x01` to address entry+6 (big-endian byte 2 of the second word). Otherwise it makes no such write.
- R7: If the access is a write, the key allows writing and second-word bit 7 is clear, the walker writes the byte `w1[7:0]|0x80` to entry+7 (byte 3). This write comes after any R6 write.
- R8: The status is 0 (ok) or 2 (fault). Fault is reported when the match is not readable, or when the access is a write that is not permitted. It is reported only after the R6/R7 writes.
- R9: If neither group matches, the status is 1 (miss) and physAddr, permRead, permWrite and permExec are 0. No byte writes are made.
- R10: At most one read is outstanding. A memory request holds its address and direction until memReqReady. Reads are word aligned.
- R11: doneValid is a single-cycle pulse per accepted request. reqReady is high only while idle, and never together with doneValid or memReqValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Walker idle, request accepted this cycle |
| reqAddr | input | 32 | Effective address |
| reqWrite | input | 1 | Access is a store |
| userMode | input | 1 | Access is from user mode |
| segFile | input | 512 | Sixteen segment registers, segment n at bits 32n+31..32n |
| tableBase | input | 32 | Table origin (31..16) and size mask (8..0) |
| memReqValid | output | 1 | Memory request |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | 1 byte write, 0 word read |
| memReqAddr | output | 32 | Byte address |
| memWrByte | output | 8 | Byte data for writes |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read word, big-endian value |
| doneValid | output | 1 | Result pulse |
| status | output | 2 | 0 ok, 1 miss, 2 fault |
| physAddr | output | 32 | Translated address |
| permRead | output | 1 | Read allowed |
| permWrite | output | 1 | Write allowed |
| permExec | output | 1 | Execute allowed |

## Verification
The result registers load on the same clock edge that enters the done state, so status, physAddr and the permissions are valid exactly while doneValid is high. The monitor samples them on the falling edge in that cycle. A walk lasts a variable number of cycles: two request/response pairs per entry, stalls from memReqReady, and up to two byte writes. For that reason the bench never counts cycles from the request. It compares each doneValid pulse against the next expected item in the queue, including how many byte writes the memory model saw since the previous pulse. Each entry's second word is re-read from the model after the pulse, which shows which flag bytes were changed.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_MISS  = 2'd1,
    ST_FAULT = 2'd2
  } walkStatus_e;

  typedef enum logic [1:0] {
    SEL_W0    = 2'd0,
    SEL_W1    = 2'd1,
    SEL_RBYTE = 2'd2,
    SEL_CBYTE = 2'd3
  } addrSel_e;

  typedef struct packed {
    logic     load;
    logic     capW0;
    logic     capW1;
    logic     nextEntry;
    logic     startSec;
    logic     finish;
    addrSel_e addrSel;
  } walkCtl_t;

endpackage

// File: rtl/hptw_datapath.sv
module hptw_datapath
  import hptw_pkg::*;
#(
  parameter int ENTRY_COUNT = 8,
  parameter int SEG_COUNT   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkCtl_t                ctl,
  input  logic [31:0]             reqAddr,
  input  logic                    reqWrite,
  input  logic                    userMode,
  input  logic [SEG_COUNT*32-1:0] segFile,
  input  logic [31:0]             tableBase,
  input  logic [31:0]             memRspData,
  output logic                    entryMatch,
  output logic                    lastEntry,
  output logic                    onSecondary,
  output logic                    needRef,
  output logic                    needChg,
  output logic [31:0]             memReqAddr,
  output logic [7:0]              memWrByte,
  output walkStatus_e             status,
  output logic [31:0]             physAddr,
  output logic                    permRead,
  output logic                    permWrite,
  output logic                    permExec
);

  localparam int IDX_W       = $clog2(ENTRY_COUNT);
  localparam int SEG_W       = $clog2(SEG_COUNT);
  localparam int ENTRY_SHIFT = 3;

  logic [27:0]      eaQ;
  logic [30:0]      segQ;
  logic [15:0]      baseHiQ;
  logic [8:0]       baseSizeQ;
  logic [31:0]      w0Q, w1Q;
  logic             writeQ, userQ, secQ;
  logic [IDX_W-1:0] idxQ;

  logic [SEG_W-1:0] segIdx;
  logic [31:0]      segWord;
  assign segIdx  = reqAddr[31 -: SEG_W];
  assign segWord = segFile[segIdx*32 +: 32];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ <= '0; segQ <= '0; baseHiQ <= '0; baseSizeQ <= '0;
      writeQ <= 1'b0; userQ <= 1'b0; secQ <= 1'b0; idxQ <= '0;
      w0Q <= '0; w1Q <= '0;
    end else begin
      if (ctl.load) begin
        eaQ       <= reqAddr[27:0];
        segQ      <= segWord[30:0];
        baseHiQ   <= tableBase[31:16];
        baseSizeQ <= tableBase[8:0];
        writeQ    <= reqWrite;
        userQ     <= userMode;
        secQ      <= 1'b0;
        idxQ      <= '0;
      end
      if (ctl.capW0) w0Q <= memRspData;
      if (ctl.capW1) w1Q <= memRspData;
      if (ctl.nextEntry) idxQ <= idxQ + 1'b1;
      if (ctl.startSec) begin
        secQ <= 1'b1;
        idxQ <= '0;
      end
    end
  end

  // hash, group and entry address
  logic [27:0] vsid;
  logic [31:0] hashPri, hashSel, hashMask, groupAddr, entryAddr, tag;
  assign vsid      = segQ[27:0];
  assign hashPri   = ({4'b0, vsid} ^ {16'b0, eaQ[27:12]}) << 6;
  assign hashSel   = secQ ? ~hashPri : hashPri;
  assign hashMask  = {7'b0, baseSizeQ, 16'hFFC0};
  assign groupAddr = {baseHiQ, 16'h0} | (hashSel & hashMask);
  assign entryAddr = groupAddr + (32'(idxQ) << ENTRY_SHIFT);
  assign tag       = 32'h8000_0000 | ({4'b0, vsid} << 7)
                   | (secQ ? 32'h40 : 32'h0) | {26'b0, eaQ[27:22]};

  assign entryMatch  = (w0Q == tag);
  assign lastEntry   = (idxQ == IDX_W'(ENTRY_COUNT - 1));
  assign onSecondary = secQ;

  // protection key decode
  logic [2:0] key;
  logic       canRd, canWr, isFault;
  assign key = {(userQ ? segQ[29] : segQ[30]), w1Q[1:0]};

  always_comb begin
    canRd = 1'b0;
    canWr = 1'b0;
    case (key)
      3'd0, 3'd1, 3'd2, 3'd6: begin canRd = 1'b1; canWr = 1'b1; end
      3'd3, 3'd5, 3'd7:       canRd = 1'b1;
      default:                ;
    endcase
  end

  assign isFault = !canRd || (writeQ && !canWr);
  assign needRef = canRd && !w1Q[8];
  assign needChg = writeQ && canWr && !w1Q[7];

  always_comb begin
    memReqAddr = entryAddr;
    memWrByte  = 8'h00;
    case (ctl.addrSel)
      SEL_W0:    memReqAddr = entryAddr;
      SEL_W1:    memReqAddr = entryAddr + 32'd4;
      SEL_RBYTE: begin memReqAddr = entryAddr + 32'd6; memWrByte = w1Q[15:8] | 8'h01; end
      SEL_CBYTE: begin memReqAddr = entryAddr + 32'd7; memWrByte = w1Q[7:0] | 8'h80; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= ST_OK; physAddr <= '0;
      permRead <= 1'b0; permWrite <= 1'b0; permExec <= 1'b0;
    end else if (ctl.finish) begin
      if (entryMatch) begin
        status    <= isFault ? ST_FAULT : ST_OK;
        physAddr  <= {w1Q[31:12], eaQ[11:0]};
        permRead  <= canRd;
        permWrite <= canWr;
        permExec  <= 1'b1;
      end else begin
        status    <= ST_MISS;
        physAddr  <= '0;
        permRead  <= 1'b0;
        permWrite <= 1'b0;
        permExec  <= 1'b0;
      end
    end
  end

  a_r5_write_implies_read: assert property (@(posedge clk) disable iff (!rstN)
    permWrite |-> permRead);
  a_r9_miss_no_perm: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_MISS) |-> !permExec && physAddr == 32'h0);
  a_r2_sec_only_after_last: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startSec |-> lastEntry && !secQ && !entryMatch);

endmodule

// File: rtl/hptw_ctrl.sv
module hptw_ctrl
  import hptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     entryMatch,
  input  logic     lastEntry,
  input  logic     onSecondary,
  input  logic     needRef,
  input  logic     needChg,
  output logic     memReqValid,
  output logic     memReqWrite,
  output logic     doneValid,
  output walkCtl_t ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_W0, S_WT_W0, S_RD_W1, S_WT_W1,
    S_COMPARE, S_UPD_REF, S_UPD_CHG, S_DONE
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    ctl         = '0;
    ctl.addrSel = SEL_W0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneValid   = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.load = 1'b1;
          stateD   = S_RD_W0;
        end
      end
      S_RD_W0: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = S_WT_W0;
      end
      S_WT_W0: begin
        if (memRspValid) begin
          ctl.capW0 = 1'b1;
          stateD    = S_RD_W1;
        end
      end
      S_RD_W1: begin
        ctl.addrSel = SEL_W1;
        memReqValid = 1'b1;
        if (memReqReady) stateD = S_WT_W1;
      end
      S_WT_W1: begin
        ctl.addrSel = SEL_W1;
        if (memRspValid) begin
          ctl.capW1 = 1'b1;
          stateD    = S_COMPARE;
        end
      end
      S_COMPARE: begin
        if (entryMatch) begin
          if (needRef)      stateD = S_UPD_REF;
          else if (needChg) stateD = S_UPD_CHG;
          else begin
            ctl.finish = 1'b1;
            stateD     = S_DONE;
          end
        end else if (lastEntry) begin
          if (onSecondary) begin
            ctl.finish = 1'b1;
            stateD     = S_DONE;
          end else begin
            ctl.startSec = 1'b1;
            stateD       = S_RD_W0;
          end
        end else begin
          ctl.nextEntry = 1'b1;
          stateD        = S_RD_W0;
        end
      end
      S_UPD_REF: begin
        ctl.addrSel = SEL_RBYTE;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          if (needChg) stateD = S_UPD_CHG;
          else begin
            ctl.finish = 1'b1;
            stateD     = S_DONE;
          end
        end
      end
      S_UPD_CHG: begin
        ctl.addrSel = SEL_CBYTE;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          ctl.finish = 1'b1;
          stateD     = S_DONE;
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        stateD    = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !doneValid && !memReqValid);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));
  a_r8_finish_once: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finish |=> doneValid);

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int ENTRY_COUNT = 8,
  parameter int SEG_COUNT   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [31:0]             reqAddr,
  input  logic                    reqWrite,
  input  logic                    userMode,
  input  logic [SEG_COUNT*32-1:0] segFile,
  input  logic [31:0]             tableBase,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic                    memReqWrite,
  output logic [31:0]             memReqAddr,
  output logic [7:0]              memWrByte,
  input  logic                    memRspValid,
  input  logic [31:0]             memRspData,
  output logic                    doneValid,
  output logic [1:0]              status,
  output logic [31:0]             physAddr,
  output logic                    permRead,
  output logic                    permWrite,
  output logic                    permExec
);

  walkCtl_t    ctl;
  walkStatus_e statusInt;
  logic entryMatch, lastEntry, onSecondary, needRef, needChg;

  hptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .entryMatch(entryMatch), .lastEntry(lastEntry), .onSecondary(onSecondary),
    .needRef(needRef), .needChg(needChg),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .doneValid(doneValid), .ctl(ctl)
  );

  hptw_datapath #(.ENTRY_COUNT(ENTRY_COUNT), .SEG_COUNT(SEG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .userMode(userMode), .segFile(segFile), .tableBase(tableBase),
    .memRspData(memRspData), .entryMatch(entryMatch), .lastEntry(lastEntry),
    .onSecondary(onSecondary), .needRef(needRef), .needChg(needChg),
    .memReqAddr(memReqAddr), .memWrByte(memWrByte), .status(statusInt),
    .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite),
    .permExec(permExec)
  );

  assign status = statusInt;

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));
  a_r10_read_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite |-> memReqAddr[1:0] == 2'b00);
  a_r6_byte_lane: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memReqAddr[2:1] == 2'b11);
  a_r10_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> !memReqValid);

endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0, reqWrite = 1'b0, userMode = 1'b0;
  logic [31:0]  reqAddr = '0, tableBase = '0;
  logic [511:0] segFile = '0;
  logic         memReqReady = 1'b1, memRspValid = 1'b0;
  logic [31:0]  memRspData = '0;
  logic         reqReady, memReqValid, memReqWrite, doneValid;
  logic         permRead, permWrite, permExec;
  logic [31:0]  memReqAddr, physAddr;
  logic [7:0]   memWrByte;
  logic [1:0]   status;

  always #2.5 clk = ~clk;

  hpt_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .userMode(userMode),
    .segFile(segFile), .tableBase(tableBase), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memWrByte(memWrByte), .memRspValid(memRspValid),
    .memRspData(memRspData), .doneValid(doneValid), .status(status),
    .physAddr(physAddr), .permRead(permRead), .permWrite(permWrite),
    .permExec(permExec)
  );

  int checks = 0, errors = 0, cycles = 0, byteWrites = 0, writesAtDone = 0, doneCount = 0;
  bit [31:0] mem [bit [31:0]];

  typedef struct {
    string tagName;
    logic [1:0] st;
    logic [31:0] pa;
    logic rd, wr, ex;
    int writes;
  } expItem_t;
  expItem_t expQ[$];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: read answered next cycle, byte writes big-endian
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        bit [31:0] wa, tmp;
        wa  = {memReqAddr[31:2], 2'b00};
        tmp = mem.exists(wa) ? mem[wa] : 32'h0;
        tmp[(3 - memReqAddr[1:0]) * 8 +: 8] = memWrByte;
        mem[wa] = tmp;
        byteWrites++;
      end else begin
        memRspValid <= 1'b1;
        memRspData  <= mem.exists(memReqAddr) ? mem[memReqAddr] : 32'h0;
      end
    end
  end

  // stall pattern on memReqReady
  always @(negedge clk) begin
    cycles++;
    memReqReady <= (cycles % 3) != 0;
  end

  // monitor: compare each done pulse against the queue
  always @(negedge clk) begin
    if (rstN && doneValid) begin
      expItem_t e;
      doneCount++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        check(e.tagName, "status", 32'(status), 32'(e.st));
        check(e.tagName, "physAddr", physAddr, e.pa);
        check(e.tagName, "permRead", 32'(permRead), 32'(e.rd));
        check(e.tagName, "permWrite", 32'(permWrite), 32'(e.wr));
        check(e.tagName, "permExec", 32'(permExec), 32'(e.ex));
        check(e.tagName, "byteWrites", 32'(byteWrites - writesAtDone), 32'(e.writes));
      end
      writesAtDone = byteWrites;
    end
  end

  // watchdog
  initial begin
    #(5 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] groupOf(logic [31:0] seg, logic [31:0] ea,
                                          logic [31:0] base, bit sec);
    logic [31:0] h;
    h = ({4'b0, seg[27:0]} ^ {16'b0, ea[27:12]}) << 6;
    if (sec) h = ~h;
    return {base[31:16], 16'h0} | (h & {7'b0, base[8:0], 16'hFFC0});
  endfunction

  function automatic logic [31:0] tagOf(logic [31:0] seg, logic [31:0] ea, bit sec);
    return 32'h8000_0000 | ({4'b0, seg[27:0]} << 7) | (sec ? 32'h40 : 32'h0)
         | {26'b0, ea[27:22]};
  endfunction

  task automatic putEntry(logic [31:0] grp, int idx, logic [31:0] w0, logic [31:0] w1);
    mem[grp + 32'(idx * 8)]     = w0;
    mem[grp + 32'(idx * 8) + 4] = w1;
  endtask

  task automatic setSeg(logic [31:0] ea, logic [31:0] seg);
    segFile[ea[31:28] * 32 +: 32] = seg;
  endtask

  task automatic walk(string req, logic [31:0] ea, bit wr, bit usr,
                      logic [1:0] st, logic [31:0] pa, bit rd, bit wp, bit ex, int writes);
    expItem_t e;
    int startDone;
    e.tagName = req; e.st = st; e.pa = pa; e.rd = rd; e.wr = wp; e.ex = ex; e.writes = writes;
    expQ.push_back(e);
    startDone = doneCount;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = ea; reqWrite = wr; userMode = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (doneCount == startDone) @(negedge clk);
  endtask

  logic [31:0] base, seg, ea, grp, grp2;

  initial begin
    base = 32'h0010_0000;
    tableBase = base;
    repeat (3) @(negedge clk);
    // reset state (R11)
    check("R11", "reset reqReady", 32'(reqReady), 32'd1);
    check("R11", "reset doneValid", 32'(doneValid), 32'd0);
    check("R10", "reset memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;

    // R1 R4 R6: primary entry 0, key 0, read, referenced set by byte write
    mem.delete();
    ea = 32'h1234_5678; seg = 32'h00AB_CDEF; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 0, tagOf(seg, ea, 0), 32'h0077_7000);
    walk("R1", ea, 0, 0, 2'd0, 32'h0077_7678, 1, 1, 1, 1);
    check("R6", "ref bit set", mem[grp + 4], 32'h0077_7100);

    // R3 R7: entry 5, key 2, write, both flags set in two byte writes
    mem.delete();
    ea = 32'h2040_1ABC; seg = 32'h0001_2345; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 1, 32'h8000_0001, 32'h0);
    putEntry(grp, 5, tagOf(seg, ea, 0), 32'h00AB_C002);
    walk("R7", ea, 1, 0, 2'd0, 32'h00AB_CABC, 1, 1, 1, 2);
    check("R7", "ref and chg set", mem[grp + 44], 32'h00AB_C182);

    // R2: primary holds secondary-tagged entries, secondary entry 3 matches, R already set
    mem.delete();
    ea = 32'h3000_5004; seg = 32'h0055_5555; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0); grp2 = groupOf(seg, ea, base, 1);
    for (int i = 0; i < 8; i++) putEntry(grp, i, tagOf(seg, ea, 1), 32'h0F00_0000);
    putEntry(grp2, 3, tagOf(seg, ea, 1), 32'h0123_4101);
    walk("R2", ea, 0, 0, 2'd0, 32'h0123_4004, 1, 1, 1, 0);
    check("R2", "secondary entry untouched", mem[grp2 + 28], 32'h0123_4101);

    // R9: nothing matches anywhere
    mem.delete();
    ea = 32'h4ABC_D123; seg = 32'h0000_0777; setSeg(ea, seg);
    walk("R9", ea, 1, 0, 2'd1, 32'h0, 0, 0, 0, 0);

    // R5 R8: supervisor key bit -> key 4, read denied, no flag write
    mem.delete();
    ea = 32'h5001_2000; seg = 32'h4000_0ABC; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 2, tagOf(seg, ea, 0), 32'h0055_5000);
    walk("R8", ea, 0, 0, 2'd2, 32'h0055_5000, 0, 0, 1, 0);
    check("R6", "no ref on key4", mem[grp + 20], 32'h0055_5000);

    // R8: key 3 write denied, ref still set, chg not set
    mem.delete();
    ea = 32'h6002_3010; seg = 32'h0000_1234; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 7, tagOf(seg, ea, 0), 32'h0066_6003);
    walk("R8", ea, 1, 0, 2'd2, 32'h0066_6010, 1, 0, 1, 1);
    check("R8", "ref set chg clear", mem[grp + 60], 32'h0066_6103);

    // R5: user key bit with pp 2 -> key 6 read/write
    mem.delete();
    ea = 32'h7003_4020; seg = 32'h2000_4321; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 0, tagOf(seg, ea, 0), 32'h0011_1182);
    walk("R5", ea, 1, 1, 2'd0, 32'h0011_1020, 1, 1, 1, 0);

    // R5: user key bit with pp 1 -> key 5 read only, read ok, R already set
    mem.delete();
    ea = 32'h8004_5030; seg = 32'h2000_0999; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 4, tagOf(seg, ea, 0), 32'h0022_2101);
    walk("R5", ea, 0, 1, 2'd0, 32'h0022_2030, 1, 0, 1, 0);

    // R5: supervisor-key bit ignored in user mode -> key 0
    mem.delete();
    ea = 32'h9005_6040; seg = 32'h4000_0111; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 1, tagOf(seg, ea, 0), 32'h0033_3180);
    walk("R5", ea, 1, 1, 2'd0, 32'h0033_3040, 1, 1, 1, 0);

    // R3: first matching entry wins
    mem.delete();
    ea = 32'hA006_7050; seg = 32'h0000_2222; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    putEntry(grp, 2, tagOf(seg, ea, 0), 32'h0044_4180);
    putEntry(grp, 6, tagOf(seg, ea, 0), 32'h0099_9180);
    walk("R3", ea, 0, 0, 2'd0, 32'h0044_4050, 1, 1, 1, 0);

    // R1: size field widens the masked hash into bits 16 and up
    mem.delete();
    base = 32'h0020_0003; tableBase = base;
    ea = 32'hB7FF_F060; seg = 32'h0000_0000; setSeg(ea, seg);
    grp = groupOf(seg, ea, base, 0);
    check("R1", "group uses size bits", 32'(grp[17:16] != 2'b00), 32'd1);
    putEntry(grp, 0, tagOf(seg, ea, 0), 32'h0088_8000);
    walk("R1", ea, 0, 0, 2'd0, 32'h0088_8060, 1, 1, 1, 1);
    check("R6", "ref set in wide table", mem[grp + 4], 32'h0088_8100);

    repeat (3) @(negedge clk);
    check("R11", "queue drained", 32'(expQ.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule